// File: doc/BRIEF.md
# Two-Clock Dual-Port Word Memory with Byte Lanes

This block is a word memory with two symmetric ports, A and B. Each port runs on its own clock and captures its address, write word and controls on the rising edge. A word is 18 bits wide and is split into two 9-bit lanes. Bits 0 to 8 form the lower lane and bits 9 to 17 the upper lane. An active-low select input picks each lane, so one access can write or read either lane alone or both together.

A port is active only while its active-low enable `cs0_n` is low and its active-high enable `cs1` is high. Any other pairing leaves the port idle. Reads return a data word and one drive flag per lane. The port's `oe_n` input clears those flags at once, with no clock edge needed. A static `pipe` input sets the read latency for each port. When it is low the read is flow-through: the data follows the capturing edge. When it is high the read is pipelined and the data comes one cycle later.

Both ports can reach any word, including the same word in the same cycle. When the two ports write the same lane of the same address on the same edge, port A's data is stored. A read that meets a write to its own address returns the word as it was before that write. The depth is set by `ADDR_W`, and a full-size instance uses `ADDR_W = 15`, which gives 32768 words.

Top module: `dp_lane_ram`

## Requirements
- R1: A word written through one port is read back through either port as all 18 bits, with bits 0..8 as the lower lane and bits 9..17 as the upper lane.
- R2: A port is enabled only when `cs0_n` is 0 and `cs1` is 1. Any other pairing writes nothing and leaves both drive flags of that port at 0 after the edge.
- R3: On an enabled write (`we_n` = 0), only lanes whose select (`lb_n` for bit 0 of the flags, `ub_n` for bit 1) is 0 are stored. With both selects at 1 the word is unchanged.
- R4: On an enabled read (`we_n` = 1), a drive flag is 1 only for a selected lane. `rdata` bits of a lane whose flag is 0 read as 0.
- R5: While `oe_n` is 1, both drive flags and all `rdata` bits of that port are 0 with no clock edge needed. When `oe_n` returns to 0, the read state held in the port comes back.
- R6: With `pipe` = 0, the data and flags of a read are valid after the rising edge that captures its address.
- R7: With `pipe` = 1, the same data and flags are valid one rising edge later. Back-to-back reads therefore show the previous address's word.
- R8: When both ports write the same lane of the same address on one edge, port A's data is kept for that lane. Lanes written by only one port take that port's data.
- R9: A read that shares an edge with a write to its address from the other port returns the word held before that write.
- R10: While reset is asserted and after it is released, both drive flags are 0 and `rdata` is 0 until a read is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a_n | input | 1 | Port A read-path reset, active low |
| pipe_a | input | 1 | Port A latency: 0 flow-through, 1 pipelined |
| cs0_n_a | input | 1 | Port A enable, active low |
| cs1_a | input | 1 | Port A enable, active high |
| we_n_a | input | 1 | Port A 0 write, 1 read |
| ub_n_a | input | 1 | Port A upper-lane select, active low |
| lb_n_a | input | 1 | Port A lower-lane select, active low |
| oe_n_a | input | 1 | Port A asynchronous output disable when 1 |
| addr_a | input | ADDR_W | Port A word address |
| wdata_a | input | 2*LANE_W | Port A write word |
| rdata_a | output | 2*LANE_W | Port A read word, zero in undriven lanes |
| drv_a | output | 2 | Port A lane drive flags, bit 1 upper |
| clk_b | input | 1 | Port B clock |
| rst_b_n | input | 1 | Port B read-path reset, active low |
| pipe_b | input | 1 | Port B latency: 0 flow-through, 1 pipelined |
| cs0_n_b | input | 1 | Port B enable, active low |
| cs1_b | input | 1 | Port B enable, active high |
| we_n_b | input | 1 | Port B 0 write, 1 read |
| ub_n_b | input | 1 | Port B upper-lane select, active low |
| lb_n_b | input | 1 | Port B lower-lane select, active low |
| oe_n_b | input | 1 | Port B asynchronous output disable when 1 |
| addr_b | input | ADDR_W | Port B word address |
| wdata_b | input | 2*LANE_W | Port B write word |
| rdata_b | output | 2*LANE_W | Port B read word, zero in undriven lanes |
| drv_b | output | 2 | Port B lane drive flags, bit 1 upper |

## Verification
Stored contents are not visible until they are read. A lane that was wrongly masked, or a collision that was resolved the wrong way, therefore shows up only on the first later read of that address. The bench reads every address back right after each write sweep so that such a fault is caught within a few cycles. Faults in the read path are seen much sooner. A wrong latency stage or a wrong flag gate shows in `drv` and `rdata` at the first sample after the capturing edge, or after the following edge in pipelined mode. An `oe_n` fault shows within the same cycle, before any edge.

// File: rtl/dp_lane_ram.sv
module dp_lane_ram #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9
) (
  input  logic                  clk_a,
  input  logic                  rst_a_n,
  input  logic                  pipe_a,
  input  logic                  cs0_n_a,
  input  logic                  cs1_a,
  input  logic                  we_n_a,
  input  logic                  ub_n_a,
  input  logic                  lb_n_a,
  input  logic                  oe_n_a,
  input  logic [ADDR_W-1:0]     addr_a,
  input  logic [2*LANE_W-1:0]   wdata_a,
  output logic [2*LANE_W-1:0]   rdata_a,
  output logic [1:0]            drv_a,
  input  logic                  clk_b,
  input  logic                  rst_b_n,
  input  logic                  pipe_b,
  input  logic                  cs0_n_b,
  input  logic                  cs1_b,
  input  logic                  we_n_b,
  input  logic                  ub_n_b,
  input  logic                  lb_n_b,
  input  logic                  oe_n_b,
  input  logic [ADDR_W-1:0]     addr_b,
  input  logic [2*LANE_W-1:0]   wdata_b,
  output logic [2*LANE_W-1:0]   rdata_b,
  output logic [1:0]            drv_b
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WORD_W = 2 * LANE_W;

  // Each port owns its own copy of the array; a pair of tag bits per lane
  // records which copy holds the newest data (equal tags: port A).
  logic [WORD_W-1:0] mem_a [DEPTH];
  logic [WORD_W-1:0] mem_b [DEPTH];
  logic [1:0]        tag_a [DEPTH];
  logic [1:0]        tag_b [DEPTH];

  logic       en_a, en_b;
  logic [1:0] sel_a, sel_b, wl_a, wl_b, clash, wl_b_eff, rl_a, rl_b;

  assign en_a  = !cs0_n_a && cs1_a;
  assign en_b  = !cs0_n_b && cs1_b;
  assign sel_a = ~{ub_n_a, lb_n_a};
  assign sel_b = ~{ub_n_b, lb_n_b};
  assign wl_a  = (en_a && !we_n_a) ? sel_a : 2'b00;
  assign wl_b  = (en_b && !we_n_b) ? sel_b : 2'b00;
  assign rl_a  = (en_a &&  we_n_a) ? sel_a : 2'b00;
  assign rl_b  = (en_b &&  we_n_b) ? sel_b : 2'b00;
  assign clash    = (addr_a == addr_b) ? (wl_a & wl_b) : 2'b00;
  assign wl_b_eff = wl_b & ~clash;

  always_ff @(posedge clk_a) begin
    for (int l = 0; l < 2; l++) begin
      if (wl_a[l]) begin
        mem_a[addr_a][l*LANE_W +: LANE_W] <= wdata_a[l*LANE_W +: LANE_W];
        tag_a[addr_a][l] <= tag_b[addr_a][l];
      end
    end
  end

  always_ff @(posedge clk_b) begin
    for (int l = 0; l < 2; l++) begin
      if (wl_b_eff[l]) begin
        mem_b[addr_b][l*LANE_W +: LANE_W] <= wdata_b[l*LANE_W +: LANE_W];
        tag_b[addr_b][l] <= ~tag_a[addr_b][l];
      end
    end
  end

  logic [WORD_W-1:0] cur_a, cur_b;
  always_comb begin
    for (int l = 0; l < 2; l++) begin
      cur_a[l*LANE_W +: LANE_W] = (tag_a[addr_a][l] == tag_b[addr_a][l]) ?
        mem_a[addr_a][l*LANE_W +: LANE_W] : mem_b[addr_a][l*LANE_W +: LANE_W];
      cur_b[l*LANE_W +: LANE_W] = (tag_a[addr_b][l] == tag_b[addr_b][l]) ?
        mem_a[addr_b][l*LANE_W +: LANE_W] : mem_b[addr_b][l*LANE_W +: LANE_W];
    end
  end

  logic [WORD_W-1:0] q1_a, q2_a, q1_b, q2_b;
  logic [1:0]        f1_a, f2_a, f1_b, f2_b;

  always_ff @(posedge clk_a or negedge rst_a_n) begin
    if (!rst_a_n) begin
      q1_a <= '0; q2_a <= '0; f1_a <= '0; f2_a <= '0;
    end else begin
      q1_a <= cur_a; f1_a <= rl_a;
      q2_a <= q1_a;  f2_a <= f1_a;
    end
  end

  always_ff @(posedge clk_b or negedge rst_b_n) begin
    if (!rst_b_n) begin
      q1_b <= '0; q2_b <= '0; f1_b <= '0; f2_b <= '0;
    end else begin
      q1_b <= cur_b; f1_b <= rl_b;
      q2_b <= q1_b;  f2_b <= f1_b;
    end
  end

  logic [WORD_W-1:0] qs_a, qs_b;
  assign qs_a  = pipe_a ? q2_a : q1_a;
  assign qs_b  = pipe_b ? q2_b : q1_b;
  assign drv_a = oe_n_a ? 2'b00 : (pipe_a ? f2_a : f1_a);
  assign drv_b = oe_n_b ? 2'b00 : (pipe_b ? f2_b : f1_b);
  assign rdata_a = {{LANE_W{drv_a[1]}} & qs_a[WORD_W-1:LANE_W],
                    {LANE_W{drv_a[0]}} & qs_a[LANE_W-1:0]};
  assign rdata_b = {{LANE_W{drv_b[1]}} & qs_b[WORD_W-1:LANE_W],
                    {LANE_W{drv_b[0]}} & qs_b[LANE_W-1:0]};

  // R2
  deselect_a_chk: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    !en_a |=> (f1_a == 2'b00));
  // R2
  deselect_b_chk: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    !en_b |=> (f1_b == 2'b00));
  // R4
  lane_read_chk: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    (en_a && we_n_a) |=> (f1_a == $past(~{ub_n_a, lb_n_a})));
  // R6
  flow_drive_chk: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    (en_a && we_n_a && !pipe_a) |=> (oe_n_a || pipe_a || drv_a == $past(sel_a)));
  // R8
  clash_win_chk: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    (|clash) |=> (((tag_a[$past(addr_b)] ~^ tag_b[$past(addr_b)]) & $past(clash))
                  == $past(clash)));
endmodule

// File: tb/dp_lane_ram_tb.sv
module dp_lane_ram_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int LW = 9;
  localparam int NW = 1 << AW;

  logic clk_a = 0, clk_b = 0, rst_a_n = 0, rst_b_n = 0;
  logic pipe_a = 0, cs0_n_a = 1, cs1_a = 0, we_n_a = 1, ub_n_a = 1, lb_n_a = 1, oe_n_a = 0;
  logic pipe_b = 0, cs0_n_b = 1, cs1_b = 0, we_n_b = 1, ub_n_b = 1, lb_n_b = 1, oe_n_b = 0;
  logic [AW-1:0] addr_a = 0, addr_b = 0;
  logic [2*LW-1:0] wdata_a = 0, wdata_b = 0, rdata_a, rdata_b;
  logic [1:0] drv_a, drv_b;

  logic [2*LW-1:0] mdl [NW];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) begin clk_a = ~clk_a; clk_b = ~clk_b; end

  dp_lane_ram #(.ADDR_W(AW), .LANE_W(LW)) u_dut (
    .clk_a, .rst_a_n, .pipe_a, .cs0_n_a, .cs1_a, .we_n_a, .ub_n_a, .lb_n_a, .oe_n_a,
    .addr_a, .wdata_a, .rdata_a, .drv_a,
    .clk_b, .rst_b_n, .pipe_b, .cs0_n_b, .cs1_b, .we_n_b, .ub_n_b, .lb_n_b, .oe_n_b,
    .addr_b, .wdata_b, .rdata_b, .drv_b);

  function automatic logic [2*LW-1:0] pat(int a, int s);
    return 18'((a * 2731 + s * 977) ^ 18'h15A3C);
  endfunction
  function automatic logic [2*LW-1:0] lmask(logic [1:0] l);
    return {{LW{l[1]}}, {LW{l[0]}}};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_a); @(negedge clk_a);
  endtask

  task automatic port_a(logic c0n, logic c1, logic wen, logic [1:0] lanes, int a, logic [2*LW-1:0] d);
    cs0_n_a = c0n; cs1_a = c1; we_n_a = wen; {ub_n_a, lb_n_a} = ~lanes;
    addr_a = AW'(a); wdata_a = d;
  endtask
  task automatic port_b(logic c0n, logic c1, logic wen, logic [1:0] lanes, int a, logic [2*LW-1:0] d);
    cs0_n_b = c0n; cs1_b = c1; we_n_b = wen; {ub_n_b, lb_n_b} = ~lanes;
    addr_b = AW'(a); wdata_b = d;
  endtask
  task automatic idle();
    port_a(1, 0, 1, 2'b00, 0, '0);
    port_b(1, 0, 1, 2'b00, 0, '0);
  endtask
  task automatic mwr(int a, logic [1:0] l, logic [2*LW-1:0] d);
    mdl[a] = (mdl[a] & ~lmask(l)) | (d & lmask(l));
  endtask

  initial begin
    repeat (20000) @(posedge clk_a);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NW; i++) mdl[i] = '0;
    repeat (3) @(negedge clk_a);
    // R10 reset state
    chk("R10 drv_a in reset", 32'(drv_a), 0);
    chk("R10 rdata_b in reset", 32'(rdata_b), 0);
    rst_a_n = 1; rst_b_n = 1;
    tick();
    chk("R10 drv_a after reset", 32'(drv_a), 0);
    chk("R10 drv_b after reset", 32'(drv_b), 0);

    // R1 full-word writes through A
    for (int a = 0; a < NW; a++) begin
      port_a(0, 1, 0, 2'b11, a, pat(a, 1)); tick(); mwr(a, 2'b11, pat(a, 1));
    end
    idle();
    // R1 / R6 flow-through reads through B
    for (int a = 0; a < NW; a++) begin
      port_b(0, 1, 1, 2'b11, a, '0); tick();
      chk("R1 word via B", 32'(rdata_b), 32'(mdl[a]));
      chk("R6 flow drv_b", 32'(drv_b), 3);
    end
    idle();

    // R3 lane writes through B, every lane pattern
    for (int a = 0; a < NW; a++) begin
      port_b(0, 1, 0, 2'(a % 4), a, pat(a, 2)); tick(); mwr(a, 2'(a % 4), pat(a, 2));
    end
    idle();
    // R3 / R4 read every lane select through A
    for (int a = 0; a < NW; a++) begin
      for (int s = 0; s < 4; s++) begin
        port_a(0, 1, 1, 2'(s), a, '0); tick();
        chk("R4 lane flags", 32'(drv_a), 32'(s));
        chk("R3 lane data", 32'(rdata_a), 32'(mdl[a] & lmask(2'(s))));
      end
    end
    idle();

    // R2 deselect combinations
    for (int c = 0; c < 3; c++) begin
      logic c0n, c1;
      c0n = (c != 2); c1 = (c == 0);
      port_a(c0n, c1, 0, 2'b11, 3, '1); tick();
      port_a(c0n, c1, 1, 2'b11, 3, '0); tick();
      chk("R2 deselect drv_a", 32'(drv_a), 0);
      chk("R2 deselect rdata_a", 32'(rdata_a), 0);
    end
    port_a(0, 1, 1, 2'b11, 3, '0); tick();
    chk("R2 no write when deselected", 32'(rdata_a), 32'(mdl[3]));

    // R5 asynchronous output disable
    port_a(0, 1, 1, 2'b11, 5, '0); tick();
    idle();
    #1 oe_n_a = 1; #1;
    chk("R5 oe high drv_a", 32'(drv_a), 0);
    chk("R5 oe high rdata_a", 32'(rdata_a), 0);
    oe_n_a = 0; #1;
    chk("R5 oe restored drv_a", 32'(drv_a), 3);
    chk("R5 oe restored rdata_a", 32'(rdata_a), 32'(mdl[5]));
    tick();

    // R7 pipelined back-to-back reads
    pipe_a = 1;
    for (int a = 0; a < NW; a++) begin
      port_a(0, 1, 1, 2'b11, a, '0); tick();
      if (a > 0) begin
        chk("R7 pipe data", 32'(rdata_a), 32'(mdl[a-1]));
        chk("R7 pipe drv", 32'(drv_a), 3);
      end
    end
    idle(); tick();
    chk("R7 pipe last", 32'(rdata_a), 32'(mdl[NW-1]));
    tick();
    chk("R7 pipe drained", 32'(drv_a), 0);
    pipe_a = 0;

    // R8 same-edge write collisions, all lane mixes
    for (int la = 1; la < 4; la++) begin
      for (int lb = 1; lb < 4; lb++) begin
        int a;
        a = la * 4 + lb;
        port_a(0, 1, 0, 2'(la), a, pat(a, 5));
        port_b(0, 1, 0, 2'(lb), a, pat(a, 6));
        tick();
        mwr(a, 2'(lb & ~la), pat(a, 6));
        mwr(a, 2'(la), pat(a, 5));
      end
    end
    idle();
    for (int la = 1; la < 4; la++) begin
      for (int lb = 1; lb < 4; lb++) begin
        port_b(0, 1, 1, 2'b11, la * 4 + lb, '0); tick();
        chk("R8 collision result", 32'(rdata_b), 32'(mdl[la * 4 + lb]));
      end
    end

    // R9 read during write from the other port
    port_a(0, 1, 1, 2'b11, 7, '0);
    port_b(0, 1, 0, 2'b11, 7, pat(7, 9)); tick();
    chk("R9 A sees old word", 32'(rdata_a), 32'(mdl[7]));
    mwr(7, 2'b11, pat(7, 9));
    port_b(1, 0, 1, 2'b00, 0, '0); tick();
    chk("R9 A sees new word", 32'(rdata_a), 32'(mdl[7]));
    port_b(0, 1, 1, 2'b11, 9, '0);
    port_a(0, 1, 0, 2'b01, 9, pat(9, 11)); tick();
    chk("R9 B sees old word", 32'(rdata_b), 32'(mdl[9]));
    mwr(9, 2'b01, pat(9, 11));
    port_a(1, 0, 1, 2'b00, 0, '0); tick();
    chk("R9 B sees new word", 32'(rdata_b), 32'(mdl[9]));
    idle(); tick();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule